// File: doc/BRIEF.md
# Staged power clamp sequencer

This block drives the 8-bit control word of the power switch that feeds one processor core. A switch word of 0xFF holds the switch fully closed, so the core is unpowered. A word of 0x00 holds it fully open. Opening the switch in one jump would draw a large inrush current. The block therefore opens it through a fixed ladder of intermediate words and lets the rail settle for a fixed time after each rung. Closing needs no such care, so it takes a single step.

Two one-cycle request strobes control the block: one asks to open the switch and one asks to close it. While an operation runs, `busy` is high. When the operation ends, `done` pulses for one cycle. A parameter gives the number of clock cycles in one microsecond, and every settling wait is derived from it.

Top module: `clampSeq`

## Requirements
- R1: During reset and after it is released, `switchWord` is 0xFF, `busy` is 0 and `done` is 0.
- R2: An open request accepted while `switchWord` is not 0x00 drives `switchWord` through 0xFF, 0xFE, 0xF8, 0xF0 and 0x00, in that order. The first word appears in the cycle after the request.
- R3: Each word of the opening ladder is held for exactly 10 × CYC_PER_US cycles. `busy` is high for 5 × 10 × CYC_PER_US cycles, and `done` rises in the cycle after `busy` falls.
- R4: An open request accepted while `switchWord` is already 0x00 changes no word and leaves `busy` low. `done` pulses in the cycle after the request.
- R5: A close request accepted while idle sets `switchWord` to 0xFF in the next cycle. `busy` then stays high for 10 × CYC_PER_US cycles, after which `done` pulses.
- R6: A close request while `switchWord` is already 0xFF still performs the full settling wait before `done`.
- R7: Open and close requests sampled while `busy` is high are ignored. This includes a request on the last busy cycle. The word sequence and the timing are unchanged.
- R8: `done` is high for one cycle per finished operation and is never high while `busy` is high.
- R9: When open and close requests are sampled together while idle, the close request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enReq | input | 1 | Request to open the switch (one-cycle strobe) |
| disReq | input | 1 | Request to close the switch (one-cycle strobe) |
| switchWord | output | 8 | Power switch control word (0xFF closed, 0x00 open) |
| busy | output | 1 | An open or close operation is in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |

## Verification
Two cases can fall in the same cycle. The first is an open and a close request arriving together while idle. The bench provokes it by raising both strobes in one cycle, and expects the word to return to 0xFF with a full close wait. The second is a new request on the final busy cycle of an operation, the cycle in which that operation completes. The bench holds a close strobe across that exact edge and checks that `done` fires, that the word stays at 0x00, and that no new operation starts. A behavioural per-cycle model also compares every cycle of a long random request stream, which hits both cases many times.

// File: rtl/clampSeqPkg.sv
package clampSeqPkg;

  localparam int WORD_W     = 8;
  localparam int STEP_COUNT = 5;
  localparam int STEP_IDX_W = $clog2(STEP_COUNT);

  localparam logic [WORD_W-1:0] WORD_CLOSED = '1;
  localparam logic [WORD_W-1:0] WORD_OPEN   = '0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RAMP,
    ST_SHUT
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  loadClosed;
    logic                  loadStep;
    logic [STEP_IDX_W-1:0] stepSel;
    logic                  armWait;
  } pathCmd_t;

  // Opening ladder: rung k clears a growing group of low bits
  function automatic logic [WORD_W-1:0] ladderWord(input logic [STEP_IDX_W-1:0] idx);
    logic [WORD_W-1:0] w;
    case (idx)
      STEP_IDX_W'(0): w = 8'hFF;
      STEP_IDX_W'(1): w = 8'hFE;
      STEP_IDX_W'(2): w = 8'hF8;
      STEP_IDX_W'(3): w = 8'hF0;
      default:        w = 8'h00;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/clampSeqPath.sv
module clampSeqPath
  import clampSeqPkg::*;
#(
  parameter int WAIT_CYC = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCmd_t          cmd,
  output logic [WORD_W-1:0] switchWord,
  output logic              waitDone,
  output logic              wordOpen
);

  localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);

  logic [WORD_W-1:0] wordQ;
  logic [CNT_W-1:0]  waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= WORD_CLOSED;
    end else if (cmd.loadClosed) begin
      wordQ <= WORD_CLOSED;
    end else if (cmd.loadStep) begin
      wordQ <= ladderWord(cmd.stepSel);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (cmd.armWait) begin
      waitCnt <= CNT_LOAD;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign switchWord = wordQ;
  assign waitDone   = (waitCnt == '0);
  assign wordOpen   = (wordQ == WORD_OPEN);

  // R3
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitCnt != '0) |=> $stable(wordQ));

  // R2
  ladder_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordQ != $past(wordQ)) |-> ((wordQ == WORD_CLOSED) || (wordQ < $past(wordQ))));

endmodule

// File: rtl/clampSeqCtrl.sv
module clampSeqCtrl
  import clampSeqPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enReq,
  input  logic     disReq,
  input  logic     waitDone,
  input  logic     wordOpen,
  output pathCmd_t cmd,
  output logic     busy,
  output logic     done
);

  localparam logic [STEP_IDX_W-1:0] LAST_IDX = STEP_IDX_W'(STEP_COUNT - 1);

  seqState_t             stateQ, stateNxt;
  logic [STEP_IDX_W-1:0] stepIdxQ, idxNxt;
  logic                  doneQ, doneNxt;

  always_comb begin
    stateNxt = stateQ;
    idxNxt   = stepIdxQ;
    doneNxt  = 1'b0;
    cmd      = '0;
    case (stateQ)
      ST_IDLE: begin
        if (disReq) begin
          // close wins over a simultaneous open
          cmd.loadClosed = 1'b1;
          cmd.armWait    = 1'b1;
          stateNxt       = ST_SHUT;
        end else if (enReq) begin
          if (wordOpen) begin
            doneNxt = 1'b1;
          end else begin
            idxNxt      = '0;
            cmd.loadStep = 1'b1;
            cmd.stepSel  = '0;
            cmd.armWait  = 1'b1;
            stateNxt     = ST_RAMP;
          end
        end
      end
      ST_RAMP: begin
        if (waitDone) begin
          if (stepIdxQ == LAST_IDX) begin
            stateNxt = ST_IDLE;
            doneNxt  = 1'b1;
          end else begin
            idxNxt       = stepIdxQ + 1'b1;
            cmd.loadStep = 1'b1;
            cmd.stepSel  = stepIdxQ + 1'b1;
            cmd.armWait  = 1'b1;
          end
        end
      end
      ST_SHUT: begin
        if (waitDone) begin
          stateNxt = ST_IDLE;
          doneNxt  = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      stepIdxQ <= '0;
      doneQ    <= 1'b0;
    end else begin
      stateQ   <= stateNxt;
      stepIdxQ <= idxNxt;
      doneQ    <= doneNxt;
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busy);

  // R3
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !waitDone) |=> (!doneQ && busy));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (enReq || disReq) && !waitDone) |=> (stateQ == $past(stateQ) && stepIdxQ == $past(stepIdxQ)));

endmodule

// File: rtl/clampSeq.sv
module clampSeq
  import clampSeqPkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int SETTLE_US  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enReq,
  input  logic              disReq,
  output logic [WORD_W-1:0] switchWord,
  output logic              busy,
  output logic              done
);

  localparam int WAIT_CYC = SETTLE_US * CYC_PER_US;

  pathCmd_t cmd;
  logic     waitDone;
  logic     wordOpen;

  clampSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enReq    (enReq),
    .disReq   (disReq),
    .waitDone (waitDone),
    .wordOpen (wordOpen),
    .cmd      (cmd),
    .busy     (busy),
    .done     (done)
  );

  clampSeqPath #(.WAIT_CYC(WAIT_CYC)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .switchWord (switchWord),
    .waitDone   (waitDone),
    .wordOpen   (wordOpen)
  );

  // R4
  open_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && enReq && !disReq && switchWord == WORD_OPEN) |=> (done && !busy && switchWord == WORD_OPEN));

  // R9
  close_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && disReq) |=> (busy && switchWord == WORD_CLOSED && !done));

endmodule

// File: tb/clampSeq_bench.sv
`timescale 1ns/1ps
module clampSeq_bench;

  localparam int CPU = 2;
  localparam int W   = 10 * CPU;

  logic       clk = 1'b0;
  logic       rstN;
  logic       enReq;
  logic       disReq;
  logic [7:0] switchWord;
  logic       busy;
  logic       done;

  int tests = 0;
  int fails = 0;
  bit modelOn = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  int mWord, mBusy, mDone, mLeft;
  int ladderQ[$];
  int lad[5] = '{8'hFF, 8'hFE, 8'hF8, 8'hF0, 8'h00};

  always #5 clk = ~clk;

  clampSeq #(.CYC_PER_US(CPU)) u_clampSeq (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq),
    .switchWord(switchWord), .busy(busy), .done(done)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWord = 8'hFF; mBusy = 0; mDone = 0; mLeft = 0; ladderQ = {};
    end else begin
      mDone = 0;
      if (mBusy != 0) begin
        mLeft = mLeft - 1;
        if (mLeft == 0) begin
          if (ladderQ.size() > 0) begin
            mWord = ladderQ.pop_front();
            mLeft = W;
          end else begin
            mBusy = 0;
            mDone = 1;
          end
        end
      end else if (disReq) begin
        mWord = 8'hFF; mBusy = 1; mLeft = W; ladderQ = {};
      end else if (enReq) begin
        if (mWord == 0) mDone = 1;
        else begin
          ladderQ = {8'hFE, 8'hF8, 8'hF0, 8'h00};
          mWord = 8'hFF; mBusy = 1; mLeft = W;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check("R2/R3 model word", switchWord, mWord);
      check("R3/R8 model busy", busy, mBusy);
      check("R4/R8 model done", done, mDone);
    end
  end

  task automatic pulse(input bit e, input bit d);
    enReq = e; disReq = d;
    @(negedge clk);
    enReq = 1'b0; disReq = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    rstN = 1'b0; enReq = 1'b0; disReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset word", switchWord, 8'hFF);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    rstN = 1'b1;
    modelOn = 1'b1;
    @(negedge clk);
    check("R1 idle word", switchWord, 8'hFF);

    // R2 / R3 opening ladder
    pulse(1'b1, 1'b0);
    check("R2 first rung", switchWord, 8'hFF);
    check("R3 busy start", busy, 1);
    for (int k = 1; k < 5; k++) begin
      repeat (W - 1) @(negedge clk);
      check("R3 rung hold", switchWord, lad[k-1]);
      @(negedge clk);
      check("R2 rung order", switchWord, lad[k]);
    end
    repeat (W - 1) @(negedge clk);
    check("R3 final settle busy", busy, 1);
    check("R3 no early done", done, 0);
    @(negedge clk);
    check("R3 done after settle", done, 1);
    check("R8 busy low with done", busy, 0);
    @(negedge clk);
    check("R8 done single cycle", done, 0);

    // R4 already open
    pulse(1'b1, 1'b0);
    check("R4 done at once", done, 1);
    check("R4 stays idle", busy, 0);
    check("R4 word unchanged", switchWord, 8'h00);
    @(negedge clk);
    check("R4 word still open", switchWord, 8'h00);

    // R5 close
    pulse(1'b0, 1'b1);
    check("R5 closed word", switchWord, 8'hFF);
    check("R5 busy", busy, 1);
    repeat (W - 1) @(negedge clk);
    check("R5 still waiting", busy, 1);
    @(negedge clk);
    check("R5 done", done, 1);
    @(negedge clk);

    // R6 close while closed
    pulse(1'b0, 1'b1);
    check("R6 busy", busy, 1);
    repeat (W - 1) @(negedge clk);
    check("R6 no early done", done, 0);
    @(negedge clk);
    check("R6 done after wait", done, 1);
    @(negedge clk);

    // R7 requests while busy
    pulse(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    pulse(1'b0, 1'b1);
    check("R7 close ignored", switchWord, 8'hFF);
    check("R7 still busy", busy, 1);
    repeat (W - 4) @(negedge clk);
    check("R7 ladder continues", switchWord, 8'hFE);
    repeat (4 * W - 1) @(negedge clk);
    check("R7 last busy cycle", busy, 1);
    pulse(1'b0, 1'b1);
    check("R7 done on last edge", done, 1);
    check("R7 word open", switchWord, 8'h00);
    @(negedge clk);
    check("R7 request on last edge ignored", busy, 0);
    check("R7 word kept", switchWord, 8'h00);

    // R9 simultaneous requests
    pulse(1'b1, 1'b1);
    check("R9 close wins word", switchWord, 8'hFF);
    check("R9 close wins busy", busy, 1);
    check("R9 no skip done", done, 0);
    repeat (W - 1) @(negedge clk);
    @(negedge clk);
    check("R9 done after close wait", done, 1);

    // random stream against model
    for (int i = 0; i < 3000; i++) begin
      enReq  = ($urandom % 8) == 0;
      disReq = ($urandom % 24) == 0;
      @(negedge clk);
    end
    enReq = 1'b0; disReq = 1'b0;
    repeat (6 * W) @(negedge clk);
    finishRun();
  end

endmodule